// File: doc/BRIEF.md
# Bus Target Response Timing Monitor

This block watches one PCI-X bus segment without driving it. On every clock it samples the active-low FRAME#, IRDY#, TRDY#, STOP# and DEVSEL# lines. During the attribute phase it also samples a two-bit command class decoded elsewhere. From these it checks that the addressed target answers within its deadlines and keeps to the data-phase rules. For each rule it finds broken, it raises a one-clock pulse together with a rule-specific code. After reporting, it ignores the rest of the transaction and picks up again once the bus is idle.

The clock on which FRAME# is first seen asserted is clock 0, the address phase. Clock 1 is the attribute phase. A clock counter, saturating at its maximum, measures every later clock from clock 0.

The target response on a clock is read from the triple {DEVSEL, STOP, TRDY}, taken as asserted-high:
- 101 is a data transfer.
- 111 is a disconnect, which is also used for a single data phase disconnect.
- 110 is a retry.
- 001 is a split response.
- 010 is a target abort.
- Any other triple means the target is still waiting.

The first non-wait response marks the first data phase. Data phases then follow on consecutive clocks. The last data phase is the first data-phase clock that comes after a clock on which FRAME# was seen deasserted, at any time from clock 1 onward. A retry, split response or abort always ends the transaction.

Top module: `pcix_tgt_timing_mon`

## Requirements
- R1: TRDY# asserted on clock 1 or clock 2 of a transaction is reported with code 1. A response without TRDY on clock 2 (such as abort, 010) is not reported.
- R2: A first response of retry (110), split response (001) or abort (010) later than clock 8 is reported with code 2. The same response on clock 8 or earlier is legal.
- R3: A first response that comes after clock 16 is reported with code 3, and so is a clock 17 with no response at all. A data transfer first seen on clock 16 is legal.
- R4: For command class 01 (memory write) or 10 (split completion), a first data transfer or disconnect on clock n is reported with code 4 when n-3 is odd. For class 11 (other) and class 00, any wait count is legal.
- R5: A wait triple (neither 101, 111, 110, 001 nor 010) on any data phase after the first is reported with code 5.
- R6: A retry (110) or split response (001) on any data phase after the first is reported with code 6.
- R7: Once a disconnect (111) has been seen, a later data transfer (101) in the same transaction is reported with code 7. Ending with an abort (010) after a disconnect is legal.
- R8: On the clock after the last data phase, or after a retry, split response or abort, any of TRDY#, STOP# or DEVSEL# still asserted is reported with code 8.
- R9: A violation sampled at clock edge k sets err_valid high for exactly the cycle after edge k, with its code on err_code. At all other times, and during reset, err_code is 0.
- R10: A transaction yields at most one report. After reset or after a report, the monitor ignores the bus until it samples FRAME# and IRDY# both deasserted. Only after that does a new FRAME# assertion start a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| cmd_class | input | 2 | Command class, valid on the attribute clock: 01 memory write, 10 split completion, others unchecked |
| err_valid | output | 1 | One-clock violation pulse |
| err_code | output | 4 | Violation code 1..8, 0 when no pulse |

## Verification
The bench sweeps the clock of the first response across the edges of every window: clocks 2 and 3 for the TRDY rule, 8 and 9 for termination, 16 and 17 for the response deadline, and even and odd wait counts under each command class. These pairs separate an off-by-one comparison from a correct one. Bursts where a single later phase is replaced by a wait, a retry, a split response or a data transfer after a disconnect show that each later-phase rule fires on its own phase, and that an abort after a disconnect stays legal. For each report the bench checks the exact clock of the pulse. Runs that hold the bus busy across reset, and runs that contain two faults in one transaction, show the resynchronisation and the single-report behaviour.

// File: rtl/pcix_tgt_timing_mon.sv
module pcix_tgt_timing_mon #(
  parameter int CNT_W         = 5,
  parameter int TERM_LIMIT    = 8,
  parameter int RESP_LIMIT    = 16,
  parameter int TRDY_EARLIEST = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic       devsel_n,
  input  logic [1:0] cmd_class,
  output logic       err_valid,
  output logic [3:0] err_code
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TERM_L  = CNT_W'(TERM_LIMIT);
  localparam logic [CNT_W-1:0] RESP_L  = CNT_W'(RESP_LIMIT);
  localparam logic [CNT_W-1:0] TRDY_L  = CNT_W'(TRDY_EARLIEST);

  localparam logic [3:0] E_EARLY   = 4'd1;  // R1
  localparam logic [3:0] E_LATE    = 4'd2;  // R2
  localparam logic [3:0] E_NORESP  = 4'd3;  // R3
  localparam logic [3:0] E_ODDWAIT = 4'd4;  // R4
  localparam logic [3:0] E_WAIT    = 4'd5;  // R5
  localparam logic [3:0] E_LATERS  = 4'd6;  // R6
  localparam logic [3:0] E_ADB     = 4'd7;  // R7
  localparam logic [3:0] E_HOLD    = 4'd8;  // R8

  typedef enum logic [2:0] {S_IDLE, S_ATTR, S_RESP, S_DATA, S_TURN, S_SKIP} st_t;

  st_t             st, nxt;
  logic [CNT_W-1:0] cnt;
  logic            pair_rule, frame_seen, disc_seen;
  logic [3:0]      code_d;

  wire [2:0] rsp = {~devsel_n, ~stop_n, ~trdy_n};
  wire r_data  = rsp == 3'b101;
  wire r_disc  = rsp == 3'b111;
  wire r_retry = rsp == 3'b110;
  wire r_split = rsp == 3'b001;
  wire r_abort = rsp == 3'b010;
  wire r_term  = r_retry | r_split | r_abort;
  wire r_xfer  = r_data | r_disc;
  wire r_wait  = ~(r_term | r_xfer);

  wire [CNT_W-1:0] waits = cnt - TRDY_L;
  wire             start = (st == S_IDLE) && !frame_n;

  always_comb begin
    nxt    = st;
    code_d = 4'd0;
    case (st)
      S_IDLE: if (!frame_n) nxt = S_ATTR;
      S_ATTR: begin
        if (!trdy_n) code_d = E_EARLY;
        else         nxt    = S_RESP;
      end
      S_RESP: begin
        if (cnt > RESP_L)                  code_d = E_NORESP;
        else if (!trdy_n && cnt < TRDY_L)  code_d = E_EARLY;
        else if (r_term) begin
          if (cnt > TERM_L) code_d = E_LATE;
          else              nxt    = S_TURN;
        end else if (r_xfer) begin
          if (pair_rule && waits[0]) code_d = E_ODDWAIT;
          else                       nxt    = frame_seen ? S_TURN : S_DATA;
        end
      end
      S_DATA: begin
        if (r_wait)                   code_d = E_WAIT;
        else if (r_retry || r_split)  code_d = E_LATERS;
        else if (disc_seen && r_data) code_d = E_ADB;
        else if (r_abort || frame_seen) nxt  = S_TURN;
      end
      S_TURN: begin
        if (!trdy_n || !stop_n || !devsel_n) code_d = E_HOLD;
        else                                 nxt    = S_SKIP;
      end
      S_SKIP: if (frame_n && irdy_n) nxt = S_IDLE;
      default: nxt = S_SKIP;
    endcase
    if (code_d != 4'd0) nxt = S_SKIP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_SKIP;
      cnt        <= '0;
      pair_rule  <= 1'b0;
      frame_seen <= 1'b0;
      disc_seen  <= 1'b0;
      err_valid  <= 1'b0;
      err_code   <= 4'd0;
    end else begin
      st        <= nxt;
      err_valid <= code_d != 4'd0;
      err_code  <= code_d;
      if (start) begin
        cnt        <= CNT_W'(1);
        frame_seen <= 1'b0;
        disc_seen  <= 1'b0;
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        frame_seen <= frame_seen | frame_n;
        if ((st == S_RESP || st == S_DATA) && r_disc) disc_seen <= 1'b1;
      end
      if (st == S_ATTR) pair_rule <= (cmd_class == 2'b01) || (cmd_class == 2'b10);
    end
  end

endmodule

// File: rtl/pcix_tgt_timing_chk.sv
module pcix_tgt_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       devsel_n,
  input logic       err_valid,
  input logic [3:0] err_code
);

  p_code_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> err_code == 4'd0);

  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code >= 4'd1 && err_code <= 4'd8));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  p_early_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 4'd1) |-> $past(!trdy_n));

  p_pair_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 4'd4) |-> $past(!trdy_n && !devsel_n));

  p_hold_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 4'd8) |-> $past(!trdy_n || !stop_n || !devsel_n));

endmodule

bind pcix_tgt_timing_mon pcix_tgt_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .devsel_n(devsel_n), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/sim_pcix_tgt_timing_mon.sv
module sim_pcix_tgt_timing_mon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
  logic [1:0] cmd_class = 2'b00;
  logic err_valid;
  logic [3:0] err_code;

  always #2.5 clk = ~clk;

  pcix_tgt_timing_mon u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .devsel_n(devsel_n), .cmd_class(cmd_class),
    .err_valid(err_valid), .err_code(err_code)
  );

  localparam logic [2:0] DT = 3'b101, DC = 3'b111, RT = 3'b110, SP = 3'b001, AB = 3'b010, WT = 3'b100;

  typedef struct packed {
    logic [1:0] cmd; logic [4:0] f; logic [2:0] first; logic [2:0] n;
    logic [2:0] rest; logic [2:0] oidx; logic [2:0] ovr; logic relbad;
    logic [3:0] exp; logic [4:0] at; logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 5'd3,  DT, 3'd4, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd9},  // R9 clean burst
    '{2'd1, 5'd3,  DT, 3'd2, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd4},  // R4 zero waits
    '{2'd1, 5'd4,  DT, 3'd2, DT, 3'd0, DT, 1'b0, 4'd4, 5'd5,  4'd4},  // R4 one wait
    '{2'd2, 5'd5,  DT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd4},  // R4 two waits
    '{2'd2, 5'd6,  DT, 3'd3, DT, 3'd0, DT, 1'b0, 4'd4, 5'd7,  4'd4},  // R4 three waits
    '{2'd3, 5'd4,  DT, 3'd2, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd4},  // R4 read, odd ok
    '{2'd3, 5'd2,  DT, 3'd2, DT, 3'd0, DT, 1'b0, 4'd1, 5'd3,  4'd1},  // R1 trdy clock 2
    '{2'd0, 5'd2,  AB, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd1},  // R1 abort clock 2
    '{2'd3, 5'd8,  RT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd2},  // R2
    '{2'd3, 5'd9,  RT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd2, 5'd10, 4'd2},  // R2
    '{2'd3, 5'd8,  SP, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd2},  // R2
    '{2'd3, 5'd9,  AB, 3'd1, DT, 3'd0, DT, 1'b0, 4'd2, 5'd10, 4'd2},  // R2
    '{2'd3, 5'd16, DT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd3},  // R3
    '{2'd3, 5'd17, DT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd3, 5'd18, 4'd3},  // R3
    '{2'd3, 5'd3,  DT, 3'd4, DT, 3'd2, WT, 1'b0, 4'd5, 5'd6,  4'd5},  // R5
    '{2'd3, 5'd3,  DT, 3'd4, DT, 3'd2, RT, 1'b0, 4'd6, 5'd6,  4'd6},  // R6
    '{2'd3, 5'd3,  DT, 3'd4, DT, 3'd2, SP, 1'b0, 4'd6, 5'd6,  4'd6},  // R6
    '{2'd3, 5'd3,  DC, 3'd4, DC, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd7},  // R7
    '{2'd3, 5'd3,  DC, 3'd4, DC, 3'd2, DT, 1'b0, 4'd7, 5'd6,  4'd7},  // R7
    '{2'd3, 5'd3,  DT, 3'd4, DT, 3'd1, DC, 1'b0, 4'd7, 5'd6,  4'd7},  // R7
    '{2'd3, 5'd3,  DC, 3'd4, DC, 3'd1, AB, 1'b0, 4'd0, 5'd0,  4'd7},  // R7
    '{2'd3, 5'd3,  DT, 3'd2, DT, 3'd0, DT, 1'b1, 4'd8, 5'd6,  4'd8},  // R8
    '{2'd3, 5'd3,  RT, 3'd1, DT, 3'd0, DT, 1'b1, 4'd8, 5'd5,  4'd8},  // R8
    '{2'd1, 5'd4,  DT, 3'd2, DT, 3'd0, DT, 1'b1, 4'd4, 5'd5,  4'd10}, // R10 two faults
    '{2'd3, 5'd3,  DT, 3'd1, DT, 3'd0, DT, 1'b0, 4'd0, 5'd0,  4'd8}   // R8 single phase
  };

  int checks = 0, errors = 0, cyc = 0, start = 0;
  int pulses = 0, got_code = 0, got_at = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input int req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (err_valid) begin pulses++; got_code = err_code; got_at = cyc - start; end
  endtask

  task automatic setbus(input bit fr, input bit ir, input logic [2:0] r);
    frame_n = ~fr; irdy_n = ~ir;
    devsel_n = ~r[2]; stop_n = ~r[1]; trdy_n = ~r[0];
  endtask

  task automatic clear();
    pulses = 0; got_code = 0; got_at = 0;
  endtask

  task automatic run_vec(input vec_t v);
    int cnt, k, fend;
    bit ended;
    logic [2:0] r;
    clear();
    tick(); start = cyc; setbus(1'b1, 1'b0, 3'b000);
    cnt = 1; k = 0; ended = 1'b0;
    fend = int'(v.f) + int'(v.n) - 2;
    while (!ended) begin
      tick();
      cmd_class = (cnt == 1) ? v.cmd : 2'b00;
      if (cnt == 1) r = 3'b000;
      else if (cnt < int'(v.f)) r = WT;
      else begin
        r = (k == 0) ? v.first : ((v.oidx != 3'd0 && k == int'(v.oidx)) ? v.ovr : v.rest);
        if (r == RT || r == SP || r == AB || k == int'(v.n) - 1) ended = 1'b1;
        k++;
      end
      setbus(cnt < fend, cnt >= 2, r);
      cnt++;
    end
    tick(); setbus(1'b0, 1'b0, v.relbad ? WT : 3'b000);
    repeat (4) begin tick(); setbus(1'b0, 1'b0, 3'b000); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R9: quiet during reset
    check(err_valid == 1'b0 && err_code == 4'd0, 9, "reset state", int'(err_code), 0);
    rst_n = 1'b1;
    repeat (2) tick();
    check(err_valid == 1'b0 && err_code == 4'd0, 9, "after reset", int'(err_code), 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
      check(pulses == ((VEC[i].exp != 4'd0) ? 1 : 0), int'(VEC[i].req), $sformatf("vec %0d pulse count", i),
            pulses, (VEC[i].exp != 4'd0) ? 1 : 0);
      check(got_code == int'(VEC[i].exp), int'(VEC[i].req), $sformatf("vec %0d code", i), got_code, int'(VEC[i].exp));
      if (VEC[i].exp != 4'd0)
        check(got_at == int'(VEC[i].at), 9, $sformatf("vec %0d pulse clock", i), got_at, int'(VEC[i].at));
    end

    // R10: reset while bus is busy with an early TRDY, then monitor must wait for idle
    clear();
    tick(); setbus(1'b1, 1'b0, 3'b000);
    tick(); setbus(1'b1, 1'b0, 3'b000);
    tick(); rst_n = 1'b0; setbus(1'b1, 1'b1, DT);
    tick(); rst_n = 1'b1;
    tick(); setbus(1'b1, 1'b0, 3'b000);
    tick(); setbus(1'b1, 1'b0, DT);
    repeat (3) tick();
    check(pulses == 0, 10, "busy bus after reset ignored", pulses, 0);
    setbus(1'b0, 1'b0, 3'b000);
    repeat (2) tick();
    run_vec(VEC[6]);
    check(pulses == 1 && got_code == 1, 10, "resync then early trdy", got_code, 1);
    run_vec(VEC[0]);
    check(pulses == 0, 10, "clean burst after resync", pulses, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule